// File: doc/BRIEF.md
# Extended-Precision Floating-Point Comparator

This unit compares two 80-bit extended-precision operands and reports their relation as a three-bit condition code, along with an invalid-operand flag and a denormal flag. Each operand is first sorted into a class: zero, denormal, normal, infinity, quiet NaN, signalling NaN, or unsupported encoding. Operands that both have ordered classes are then compared by sign and magnitude. Any NaN or unsupported operand makes the result unordered.

A mode input chooses what traps. In unordered mode, only signalling NaNs and unsupported encodings raise the invalid flag. In ordered mode, any NaN raises it as well. A mask input decides whether the condition code is written when the invalid flag is raised. Requests use a valid/ready handshake. The result lands in registers one cycle after acceptance, marked by a one-cycle done pulse, and the outputs then hold until the next request.

Top module: `fcmp_unit`

## Requirements
- R1: The code `cc` is {C3,C2,C0}, with bit 2 = C3, bit 1 = C2 and bit 0 = C0. The values are: A greater than B gives 000, A less than B gives 001, equal gives 100, unordered gives 111.
- R2: Operands with ordered classes compare by value. A positive operand exceeds a negative one. Between two positives, the larger magnitude is greater. Between two negatives, the larger magnitude is smaller. Infinities sit beyond every finite value of the same sign.
- R3: Positive zero and negative zero compare equal in every sign combination.
- R4: Operand layout, from bit 79 down, is sign, 15-bit exponent, explicit integer bit (bit 63), and 63-bit fraction. The classes are:
  - Exponent all ones with the integer bit set and a nonzero fraction is a NaN. It is quiet when fraction bit 62 is 1 and signalling otherwise.
  - An integer bit of 0 with a nonzero exponent is unsupported.
  - A zero exponent with a nonzero integer bit or fraction is a denormal.
  - NaNs and unsupported operands make the result unordered.
- R5: In unordered mode (`ordered_mode`=0), a quiet NaN in either operand gives code 111 and leaves `inv_flag` at 0.
- R6: A signalling NaN or an unsupported operand in either position sets `inv_flag` to 1 in both modes.
- R7: In ordered mode (`ordered_mode`=1), a NaN of either kind in either operand sets `inv_flag` to 1.
- R8: When `inv_flag` is set and `inv_mask`=1, `cc` becomes 111. When `inv_flag` is set and `inv_mask`=0, `cc` keeps its previous value.
- R9: `den_flag` is 1 exactly when at least one operand is a denormal.
- R10: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. On the next edge, `done` is 1 for one cycle together with the new `cc`, `inv_flag` and `den_flag`. `req_ready` is 0 while `done` is 1.
- R11: Without an accepted request, `cc`, `inv_flag` and `den_flag` keep their values and `done` stays 0.
- R12: After reset, `cc`=000, `inv_flag`=0, `den_flag`=0 and `done`=0, and `req_ready` rises within a few cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| op_a | input | 80 | First operand |
| op_b | input | 80 | Second operand |
| ordered_mode | input | 1 | 1 = any NaN traps, 0 = only signalling NaN traps |
| inv_mask | input | 1 | 1 = write the unordered code on an invalid operand |
| done | output | 1 | One-cycle pulse marking a fresh result |
| cc | output | 3 | Condition code {C3,C2,C0} |
| inv_flag | output | 1 | Invalid-operand flag of the last comparison |
| den_flag | output | 1 | Denormal flag of the last comparison |

## Verification
The denormal flag and the suppression of the condition-code write on an unmasked invalid operand can fall in the same cycle. The bench provokes this by pairing a denormal operand with a signalling NaN while the mask is clear, right after a comparison that left a known code. Both flags must then read 1, and the code must still equal the value from the previous comparison.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_DENORM,
    CLS_NORMAL,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN,
    CLS_BAD
  } fcmp_class_e;

  typedef enum logic [1:0] {
    REL_GT,
    REL_LT,
    REL_EQ
  } fcmp_rel_e;

  localparam logic [2:0] CC_GT = 3'b000;
  localparam logic [2:0] CC_LT = 3'b001;
  localparam logic [2:0] CC_EQ = 3'b100;
  localparam logic [2:0] CC_UN = 3'b111;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 15,
  parameter int FRAC_W = 63,
  localparam int OP_W  = 1 + EXP_W + 1 + FRAC_W,
  localparam int MAG_W = EXP_W + 1 + FRAC_W
) (
  input  logic [OP_W-1:0]  op,
  output fcmp_class_e      cls,
  output logic             sign,
  output logic [MAG_W-1:0] mag
);

  logic [EXP_W-1:0]  expo;
  logic              ibit;
  logic [FRAC_W-1:0] frac;
  logic              exp_max;
  logic              exp_zero;
  logic              frac_nz;
  logic              quiet;

  always_comb begin
    expo     = op[OP_W-2 -: EXP_W];
    ibit     = op[FRAC_W];
    frac     = op[FRAC_W-1:0];
    exp_max  = &expo;
    exp_zero = ~|expo;
    frac_nz  = |frac;
    quiet    = frac[FRAC_W-1];
    sign     = op[OP_W-1];
    mag      = op[MAG_W-1:0];
  end

  always_comb begin
    if (exp_zero) begin
      cls = (ibit || frac_nz) ? CLS_DENORM : CLS_ZERO;
    end else if (!ibit) begin
      cls = CLS_BAD;
    end else if (exp_max) begin
      if (!frac_nz)   cls = CLS_INF;
      else if (quiet) cls = CLS_QNAN;
      else            cls = CLS_SNAN;
    end else begin
      cls = CLS_NORMAL;
    end
  end

endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int MAG_W = 79
) (
  input  logic             sign_a,
  input  logic             sign_b,
  input  logic [MAG_W-1:0] mag_a,
  input  logic [MAG_W-1:0] mag_b,
  input  logic             zero_a,
  input  logic             zero_b,
  output fcmp_rel_e        rel
);

  logic mag_gt;
  logic mag_eq;

  always_comb begin
    mag_gt = (mag_a > mag_b);
    mag_eq = (mag_a == mag_b);
    if (zero_a && zero_b) begin
      rel = REL_EQ;
    end else if (sign_a != sign_b) begin
      rel = sign_a ? REL_LT : REL_GT;
    end else if (mag_eq) begin
      rel = REL_EQ;
    end else begin
      rel = (mag_gt ^ sign_a) ? REL_GT : REL_LT;
    end
  end

endmodule

// File: rtl/fcmp_decide.sv
module fcmp_decide
  import fcmp_pkg::*;
(
  input  fcmp_class_e cls_a,
  input  fcmp_class_e cls_b,
  input  fcmp_rel_e   rel,
  input  logic        ordered_mode,
  input  logic        inv_mask,
  output logic [2:0]  cc_new,
  output logic        cc_we,
  output logic        invalid,
  output logic        denorm
);

  logic nan_any;
  logic snan_any;
  logic bad_any;
  logic unord;

  always_comb begin
    snan_any = (cls_a == CLS_SNAN) || (cls_b == CLS_SNAN);
    nan_any  = snan_any || (cls_a == CLS_QNAN) || (cls_b == CLS_QNAN);
    bad_any  = (cls_a == CLS_BAD) || (cls_b == CLS_BAD);
    unord    = nan_any || bad_any;
    invalid  = snan_any || bad_any || (ordered_mode && nan_any);
    denorm   = (cls_a == CLS_DENORM) || (cls_b == CLS_DENORM);
  end

  always_comb begin
    if (unord) begin
      cc_new = CC_UN;
      cc_we  = !invalid || inv_mask;
    end else begin
      cc_we = 1'b1;
      case (rel)
        REL_GT:  cc_new = CC_GT;
        REL_LT:  cc_new = CC_LT;
        default: cc_new = CC_EQ;
      endcase
    end
  end

endmodule

// File: rtl/fcmp_unit.sv
module fcmp_unit
  import fcmp_pkg::*;
#(
  parameter int EXP_W   = 15,
  parameter int FRAC_W  = 63,
  parameter int SYNC_N  = 2,
  localparam int OP_W   = 1 + EXP_W + 1 + FRAC_W,
  localparam int MAG_W  = EXP_W + 1 + FRAC_W,
  localparam int N_OPS  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [OP_W-1:0] op_a,
  input  logic [OP_W-1:0] op_b,
  input  logic            ordered_mode,
  input  logic            inv_mask,
  output logic            done,
  output logic [2:0]      cc,
  output logic            inv_flag,
  output logic            den_flag
);

  logic [N_OPS-1:0][OP_W-1:0]  ops;
  fcmp_class_e                 cls   [N_OPS];
  logic [N_OPS-1:0]            sgn;
  logic [N_OPS-1:0][MAG_W-1:0] mag;
  fcmp_rel_e                   rel;
  logic [2:0]                  cc_new;
  logic                        cc_we;
  logic                        invalid;
  logic                        denorm;
  logic                        accept;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              done_q, done_d;
  logic [2:0]        cc_q, cc_d;
  logic              inv_q, inv_d;
  logic              den_q, den_d;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar i = 0; i < N_OPS; i++) begin : g_cls
    fcmp_classify #(
      .EXP_W  (EXP_W),
      .FRAC_W (FRAC_W)
    ) u_cls (
      .op   (ops[i]),
      .cls  (cls[i]),
      .sign (sgn[i]),
      .mag  (mag[i])
    );
  end

  fcmp_order #(
    .MAG_W (MAG_W)
  ) u_order (
    .sign_a (sgn[0]),
    .sign_b (sgn[1]),
    .mag_a  (mag[0]),
    .mag_b  (mag[1]),
    .zero_a (cls[0] == CLS_ZERO),
    .zero_b (cls[1] == CLS_ZERO),
    .rel    (rel)
  );

  fcmp_decide u_decide (
    .cls_a        (cls[0]),
    .cls_b        (cls[1]),
    .rel          (rel),
    .ordered_mode (ordered_mode),
    .inv_mask     (inv_mask),
    .cc_new       (cc_new),
    .cc_we        (cc_we),
    .invalid      (invalid),
    .denorm       (denorm)
  );

  // Reset release is synchronised before requests are taken.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end

  assign req_ready = rst_sync_q[SYNC_N-1] && !done_q;
  assign accept    = req_valid && req_ready;

  always_comb begin
    done_d = accept;
    cc_d   = cc_q;
    inv_d  = inv_q;
    den_d  = den_q;
    if (accept) begin
      inv_d = invalid;
      den_d = denorm;
      if (cc_we) cc_d = cc_new;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      cc_q   <= CC_GT;
      inv_q  <= 1'b0;
      den_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      cc_q   <= cc_d;
      inv_q  <= inv_d;
      den_q  <= den_d;
    end
  end

  assign done     = done_q;
  assign cc       = cc_q;
  assign inv_flag = inv_q;
  assign den_flag = den_q;

endmodule

// File: rtl/fcmp_unit_chk.sv
module fcmp_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       inv_mask,
  input logic       done,
  input logic [2:0] cc,
  input logic       inv_flag
);

  assert_done_follows_accept_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> done);

  assert_ready_low_in_done_R10: assert property (
    @(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);

  assert_hold_without_request_R11: assert property (
    @(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> (!done && $stable(cc) && $stable(inv_flag)));

  assert_cc_legal_code_R1: assert property (
    @(posedge clk) disable iff (!rst_n)
    (cc == 3'b000) || (cc == 3'b001) || (cc == 3'b100) || (cc == 3'b111));

  assert_masked_invalid_unordered_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && inv_mask) |=> (!inv_flag || cc == 3'b111));

  assert_unmasked_invalid_holds_R8: assert property (
    @(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !inv_mask) |=> (!inv_flag || $stable(cc)));

endmodule

bind fcmp_unit fcmp_unit_chk u_chk (.*);

// File: tb/fcmp_unit_test.sv
module fcmp_unit_test;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [79:0] op_a;
  logic [79:0] op_b;
  logic        ordered_mode;
  logic        inv_mask;
  logic        done;
  logic [2:0]  cc;
  logic        inv_flag;
  logic        den_flag;

  int n_checks;
  int n_fails;
  bit finished;

  fcmp_unit uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .op_a         (op_a),
    .op_b         (op_b),
    .ordered_mode (ordered_mode),
    .inv_mask     (inv_mask),
    .done         (done),
    .cc           (cc),
    .inv_flag     (inv_flag),
    .den_flag     (den_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [79:0] mk(input logic s, input logic [14:0] e,
                                     input logic j, input logic [62:0] f);
    return {s, e, j, f};
  endfunction

  localparam logic [79:0] ONE    = {1'b0, 15'd16383, 1'b1, 63'd0};
  localparam logic [79:0] TWO    = {1'b0, 15'd16384, 1'b1, 63'd0};
  localparam logic [79:0] NONE   = {1'b1, 15'd16383, 1'b1, 63'd0};
  localparam logic [79:0] NTWO   = {1'b1, 15'd16384, 1'b1, 63'd0};
  localparam logic [79:0] PZERO  = 80'd0;
  localparam logic [79:0] NZERO  = {1'b1, 79'd0};
  localparam logic [79:0] PINF   = {1'b0, 15'h7fff, 1'b1, 63'd0};
  localparam logic [79:0] NINF   = {1'b1, 15'h7fff, 1'b1, 63'd0};
  localparam logic [79:0] MAXN   = {1'b0, 15'h7ffe, 1'b1, {63{1'b1}}};
  localparam logic [79:0] QNAN   = {1'b0, 15'h7fff, 1'b1, 1'b1, 62'd3};
  localparam logic [79:0] SNAN   = {1'b1, 15'h7fff, 1'b1, 1'b0, 62'd9};
  localparam logic [79:0] DEN    = {1'b0, 15'd0, 1'b0, 63'd1};
  localparam logic [79:0] UNNORM = {1'b0, 15'd16383, 1'b0, 63'd5};
  localparam logic [79:0] PSNAN  = {1'b0, 15'h7fff, 1'b0, 1'b1, 62'd0};

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drives one request; on return the result cycle is being sampled.
  task automatic compare(input logic [79:0] a, input logic [79:0] b,
                         input logic ord, input logic msk);
    @(negedge clk);
    op_a = a; op_b = b; ordered_mode = ord; inv_mask = msk;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", "done", {7'd0, done}, 8'd1);
    chk("R10", "ready", {7'd0, req_ready}, 8'd0);
  endtask

  task automatic expect_res(input string req, input logic [2:0] ecc,
                            input logic einv, input logic eden);
    chk(req, "cc", {5'd0, cc}, {5'd0, ecc});
    chk(req, "inv", {7'd0, inv_flag}, {7'd0, einv});
    chk(req, "den", {7'd0, den_flag}, {7'd0, eden});
  endtask

  task automatic t_reset;
    chk("R12", "cc", {5'd0, cc}, 8'd0);
    chk("R12", "inv", {7'd0, inv_flag}, 8'd0);
    chk("R12", "den", {7'd0, den_flag}, 8'd0);
    chk("R12", "done", {7'd0, done}, 8'd0);
    chk("R12", "ready", {7'd0, req_ready}, 8'd1);
  endtask

  task automatic t_basic_codes;
    compare(TWO, ONE, 1'b0, 1'b1);  expect_res("R1", 3'b000, 1'b0, 1'b0);
    compare(ONE, TWO, 1'b0, 1'b1);  expect_res("R1", 3'b001, 1'b0, 1'b0);
    compare(TWO, TWO, 1'b1, 1'b1);  expect_res("R1", 3'b100, 1'b0, 1'b0);
  endtask

  task automatic t_signed_order;
    compare(NTWO, NONE, 1'b0, 1'b1); expect_res("R2", 3'b001, 1'b0, 1'b0);
    compare(NONE, NTWO, 1'b0, 1'b1); expect_res("R2", 3'b000, 1'b0, 1'b0);
    compare(NONE, TWO, 1'b0, 1'b1);  expect_res("R2", 3'b001, 1'b0, 1'b0);
    compare(PINF, MAXN, 1'b0, 1'b1); expect_res("R2", 3'b000, 1'b0, 1'b0);
    compare(NINF, NTWO, 1'b0, 1'b1); expect_res("R2", 3'b001, 1'b0, 1'b0);
  endtask

  task automatic t_zeros;
    compare(PZERO, NZERO, 1'b0, 1'b1); expect_res("R3", 3'b100, 1'b0, 1'b0);
    compare(NZERO, PZERO, 1'b1, 1'b1); expect_res("R3", 3'b100, 1'b0, 1'b0);
    compare(NZERO, ONE, 1'b0, 1'b1);   expect_res("R3", 3'b001, 1'b0, 1'b0);
  endtask

  task automatic t_quiet_unordered;
    compare(QNAN, ONE, 1'b0, 1'b0); expect_res("R5", 3'b111, 1'b0, 1'b0);
    compare(ONE, QNAN, 1'b0, 1'b1); expect_res("R5", 3'b111, 1'b0, 1'b0);
  endtask

  task automatic t_signalling;
    compare(SNAN, ONE, 1'b0, 1'b1);   expect_res("R6", 3'b111, 1'b1, 1'b0);
    compare(ONE, UNNORM, 1'b1, 1'b1); expect_res("R6", 3'b111, 1'b1, 1'b0);
    compare(PSNAN, ONE, 1'b0, 1'b1);  expect_res("R4", 3'b111, 1'b1, 1'b0);
  endtask

  task automatic t_ordered_mode;
    compare(ONE, QNAN, 1'b1, 1'b1); expect_res("R7", 3'b111, 1'b1, 1'b0);
  endtask

  task automatic t_unmasked;
    compare(ONE, TWO, 1'b0, 1'b1);  expect_res("R8", 3'b001, 1'b0, 1'b0);
    compare(SNAN, TWO, 1'b0, 1'b0); expect_res("R8", 3'b001, 1'b1, 1'b0);
    compare(QNAN, TWO, 1'b1, 1'b0); expect_res("R8", 3'b001, 1'b1, 1'b0);
  endtask

  task automatic t_denormal;
    compare(DEN, ONE, 1'b0, 1'b1);   expect_res("R9", 3'b001, 1'b0, 1'b1);
    compare(DEN, PZERO, 1'b0, 1'b1); expect_res("R9", 3'b000, 1'b0, 1'b1);
    compare(TWO, TWO, 1'b0, 1'b1);   expect_res("R9", 3'b100, 1'b0, 1'b0);
    // denormal flag and suppressed write in the same result
    compare(DEN, SNAN, 1'b0, 1'b0);  expect_res("R9", 3'b100, 1'b1, 1'b1);
  endtask

  task automatic t_idle_hold;
    compare(ONE, TWO, 1'b0, 1'b1);
    @(negedge clk);
    op_a = SNAN; op_b = DEN; inv_mask = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R11", "done", {7'd0, done}, 8'd0);
      expect_res("R11", 3'b001, 1'b0, 1'b0);
    end
  endtask

  initial begin
    n_checks = 0; n_fails = 0; finished = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0;
    op_a = '0; op_b = '0; ordered_mode = 1'b0; inv_mask = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic_codes();
    t_signed_order();
    t_zeros();
    t_quiet_unordered();
    t_signalling();
    t_ordered_mode();
    t_unmasked();
    t_denormal();
    t_idle_hold();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL R10 watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

endmodule